// File: doc/BRIEF.md
# Flag-Setting Integer ALU with Shifter

This block is the arithmetic core of a simple 32-bit processor datapath. In one cycle it combines a first operand with a second operand that has been put through a barrel shifter. The operation can be an addition, a subtraction (forward or reverse, with or without carry), a bitwise operation, a move, or a compare. A separate low-word multiply and multiply-accumulate path is also available. The result and its write-enable are combinational. The N, Z, C and V condition flags are held in a register and change at the clock edge only when the caller asks for a flag update.

Operand fetch, instruction decode and condition evaluation stay outside the block. The surrounding pipeline presents the operands, the opcode, the shift selection and the update request together, and it takes the result back in the same cycle. The flag outputs show the registered state that the next instruction will see.

Top module: `flag_alu`

## Requirements
- R1: Opcode encoding is 0 AND, 1 EOR, 2 SUB, 3 RSB, 4 ADD, 5 ADC, 6 SBC, 7 RSC, 8 TST, 9 TEQ, 10 CMP, 11 CMN, 12 ORR, 13 MOV, 14 BIC, 15 MVN. Here A is `opA` and S is the shifted `opB`. ADD gives A+S, ADC gives A+S+C, SUB gives A-S, and SBC gives A-S+C-1, all modulo 2^32.
- R2: RSB gives S-A and RSC gives S-A+C-1.
- R3: AND, EOR and ORR give the bitwise function of A and S. BIC gives A AND NOT S. MOV gives S and MVN gives NOT S.
- R4: TST, TEQ, CMP and CMN (opcodes 8 to 11) hold `resultWe` low when `mulEn` is 0. Every other opcode, and every multiply, drives it high.
- R5: When `setFlags` is 0, the flag register keeps its value across the clock edge, whatever the operation.
- R6: When `setFlags` is 1, the next Z is 1 exactly when the 32-bit result is zero, and the next N equals result bit 31. Compare operations use their internal result for this. `flags` is {N,Z,C,V} in bits 3 down to 0.
- R7: For additions with `setFlags`, C is the carry out of bit 31. For subtractions, C is the inverted borrow (1 when no borrow occurs). V is signed overflow for the operand order actually used, and this includes RSB and RSC.
- R8: For the bitwise, move and test operations with `setFlags`, C takes the last bit shifted out. C holds its value when the shift amount is 0, and V always holds.
- R9: `shType` 0 shifts S left logically, 1 shifts it right arithmetically, 2 rotates it right, and 3 behaves like 0. The amount is `shImm` when `shFromReg` is 0 and `shReg` when it is 1. An amount of 0 leaves the operand unchanged.
- R10: For register amounts of 32 or more: a left shift by exactly 32 gives 0 with carry bit 0 of the operand, and above 32 it gives 0 with carry 0. An arithmetic right shift of 32 or more fills with bit 31, which is also the carry. A rotate uses the amount modulo 32, and a non-zero multiple of 32 leaves the value unchanged with carry bit 31.
- R11: With `mulEn` 1 the opcode is ignored and the result is the low 32 bits of `opA*opB`, using the unshifted `opB`. Adding `accEn` 1 adds `opC` to that product.
- R12: A multiply with `setFlags` updates N and Z and keeps both C and V unchanged.
- R13: Reset clears all four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opCode | input | 4 | Data operation select |
| mulEn | input | 1 | Select the multiply path |
| accEn | input | 1 | Add `opC` to the product |
| setFlags | input | 1 | Update the flags at this edge |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand, before the shifter |
| opC | input | 32 | Accumulate operand |
| shType | input | 2 | Shift kind |
| shImm | input | 5 | Immediate shift amount |
| shFromReg | input | 1 | Take the amount from `shReg` |
| shReg | input | 8 | Register-supplied shift amount |
| result | output | 32 | Operation result |
| resultWe | output | 1 | Result should be written back |
| flags | output | 4 | Registered {N,Z,C,V} |

## Verification
The embedded properties are checked on every cycle. They cover the following: the flags hold whenever no update is requested; Z tracks the previous result; compares never raise the write-enable; multiplies preserve V; and zero-length shifts on bitwise updates preserve C. The directed scenarios are the only place where the actual arithmetic values are shown. These include carry-in and borrow forms, overflow in reverse subtraction, each shift kind together with its out-of-range register amounts, and the truncated product.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_AND = 4'd0, OP_EOR = 4'd1, OP_SUB = 4'd2, OP_RSB = 4'd3,
    OP_ADD = 4'd4, OP_ADC = 4'd5, OP_SBC = 4'd6, OP_RSC = 4'd7,
    OP_TST = 4'd8, OP_TEQ = 4'd9, OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } opT;

  typedef enum logic [1:0] {SH_LSL = 2'd0, SH_ASR = 2'd1, SH_ROR = 2'd2, SH_ALT = 2'd3} shT;

  typedef enum logic [2:0] {
    SRC_SUM, SRC_AND, SRC_EOR, SRC_ORR, SRC_BIC, SRC_MOV, SRC_MVN, SRC_MUL
  } srcT;

  typedef enum logic [1:0] {CIN_ZERO, CIN_ONE, CIN_FLAG} cinT;

  // strobes from control to datapath
  typedef struct packed {
    srcT  src;
    logic swapOps;
    logic invY;
    cinT  cin;
    logic wrEn;
    logic accEn;
    logic updNZ;
    logic updC;
    logic updV;
  } ctlT;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;
endpackage

// File: rtl/alu_shifter.sv
module alu_shifter
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int AMTW  = 8,
  localparam int LOGW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] din,
  input  logic [1:0]       shType,
  input  logic [AMTW-1:0]  amt,
  input  logic             cIn,
  output logic [WIDTH-1:0] dout,
  output logic             cOut
);
  logic [LOGW-1:0] rot;
  assign rot = amt[LOGW-1:0];

  always_comb begin
    dout = din;
    cOut = cIn;
    if (amt != '0) begin
      case (shT'(shType))
        SH_ASR: begin
          if (amt >= AMTW'(WIDTH)) begin
            dout = {WIDTH{din[WIDTH-1]}};
            cOut = din[WIDTH-1];
          end else begin
            dout = WIDTH'($signed(din) >>> rot);
            cOut = din[rot - LOGW'(1)];
          end
        end
        SH_ROR: begin
          if (rot == '0) begin
            cOut = din[WIDTH-1];
          end else begin
            dout = (din >> rot) | (din << (WIDTH - int'(rot)));
            cOut = din[rot - LOGW'(1)];
          end
        end
        default: begin
          if (amt > AMTW'(WIDTH)) begin
            dout = '0;
            cOut = 1'b0;
          end else if (amt == AMTW'(WIDTH)) begin
            dout = '0;
            cOut = din[0];
          end else begin
            dout = din << rot;
            cOut = din[LOGW'(WIDTH - int'(rot))];
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [3:0] opCode,
  input  logic       mulEn,
  input  logic       accEn,
  input  logic       setFlags,
  output ctlT        ctl
);
  always_comb begin
    ctl       = '0;
    ctl.src   = SRC_SUM;
    ctl.cin   = CIN_ZERO;
    ctl.wrEn  = 1'b1;
    ctl.updNZ = setFlags;
    if (mulEn) begin
      ctl.src   = SRC_MUL;
      ctl.accEn = accEn;
    end else begin
      case (opT'(opCode))
        OP_AND, OP_TST: ctl.src = SRC_AND;
        OP_EOR, OP_TEQ: ctl.src = SRC_EOR;
        OP_ORR:         ctl.src = SRC_ORR;
        OP_BIC:         ctl.src = SRC_BIC;
        OP_MOV:         ctl.src = SRC_MOV;
        OP_MVN:         ctl.src = SRC_MVN;
        OP_SUB, OP_CMP: begin ctl.invY = 1'b1; ctl.cin = CIN_ONE; end
        OP_RSB:         begin ctl.swapOps = 1'b1; ctl.invY = 1'b1; ctl.cin = CIN_ONE; end
        OP_ADC:         ctl.cin = CIN_FLAG;
        OP_SBC:         begin ctl.invY = 1'b1; ctl.cin = CIN_FLAG; end
        OP_RSC:         begin ctl.swapOps = 1'b1; ctl.invY = 1'b1; ctl.cin = CIN_FLAG; end
        default:        ;
      endcase
      ctl.wrEn = (opCode[3:2] != 2'b10);
      ctl.updC = setFlags;
      ctl.updV = setFlags && (ctl.src == SRC_SUM);
    end
  end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int AMTW  = 8,
  localparam int LOGW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlT              ctl,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] opC,
  input  logic [1:0]       shType,
  input  logic [LOGW-1:0]  shImm,
  input  logic             shFromReg,
  input  logic [AMTW-1:0]  shReg,
  output logic [WIDTH-1:0] result,
  output logic [3:0]       flags
);
  logic [3:0]       flagQ;
  logic [AMTW-1:0]  shAmt;
  logic [WIDTH-1:0] opBsh;
  logic             shCarry;

  assign shAmt = shFromReg ? shReg : AMTW'(shImm);

  alu_shifter #(.WIDTH(WIDTH), .AMTW(AMTW)) u_shift (
    .din(opB), .shType(shType), .amt(shAmt), .cIn(flagQ[FLAG_C]),
    .dout(opBsh), .cOut(shCarry)
  );

  logic [WIDTH-1:0] xOp, yOp, prod, calc;
  logic [WIDTH:0]   sum;
  logic             cinBit, ovf;

  always_comb begin
    xOp = ctl.swapOps ? opBsh : opA;
    yOp = (ctl.swapOps ? opA : opBsh) ^ {WIDTH{ctl.invY}};
    case (ctl.cin)
      CIN_ONE:  cinBit = 1'b1;
      CIN_FLAG: cinBit = flagQ[FLAG_C];
      default:  cinBit = 1'b0;
    endcase
  end

  assign sum  = {1'b0, xOp} + {1'b0, yOp} + (WIDTH+1)'(cinBit);
  assign ovf  = (xOp[WIDTH-1] == yOp[WIDTH-1]) && (sum[WIDTH-1] != xOp[WIDTH-1]);
  assign prod = opA * opB;

  always_comb begin
    case (ctl.src)
      SRC_AND: calc = opA & opBsh;
      SRC_EOR: calc = opA ^ opBsh;
      SRC_ORR: calc = opA | opBsh;
      SRC_BIC: calc = opA & ~opBsh;
      SRC_MOV: calc = opBsh;
      SRC_MVN: calc = ~opBsh;
      SRC_MUL: calc = prod + (ctl.accEn ? opC : '0);
      default: calc = sum[WIDTH-1:0];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= '0;
    end else begin
      if (ctl.updNZ) begin
        flagQ[FLAG_N] <= calc[WIDTH-1];
        flagQ[FLAG_Z] <= (calc == '0);
      end
      if (ctl.updC) flagQ[FLAG_C] <= (ctl.src == SRC_SUM) ? sum[WIDTH] : shCarry;
      if (ctl.updV) flagQ[FLAG_V] <= ovf;
    end
  end

  assign result = calc;
  assign flags  = flagQ;

  p_flags_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.updNZ |=> flagQ == $past(flagQ));

  p_zero_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.updNZ |=> flagQ[FLAG_Z] == ($past(calc) == '0));

  p_logic_keep_c_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.updC && ctl.src != SRC_SUM && shAmt == '0) |=> flagQ[FLAG_C] == $past(flagQ[FLAG_C]));

  p_mul_keep_v_r12: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.src == SRC_MUL) |=> flagQ[FLAG_V] == $past(flagQ[FLAG_V]));
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int AMTW  = 8,
  localparam int LOGW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       opCode,
  input  logic             mulEn,
  input  logic             accEn,
  input  logic             setFlags,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] opC,
  input  logic [1:0]       shType,
  input  logic [LOGW-1:0]  shImm,
  input  logic             shFromReg,
  input  logic [AMTW-1:0]  shReg,
  output logic [WIDTH-1:0] result,
  output logic             resultWe,
  output logic [3:0]       flags
);
  ctlT ctl;

  alu_ctrl u_ctrl (
    .opCode(opCode), .mulEn(mulEn), .accEn(accEn), .setFlags(setFlags), .ctl(ctl)
  );

  alu_datapath #(.WIDTH(WIDTH), .AMTW(AMTW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .opA(opA), .opB(opB), .opC(opC),
    .shType(shType), .shImm(shImm), .shFromReg(shFromReg), .shReg(shReg),
    .result(result), .flags(flags)
  );

  assign resultWe = ctl.wrEn;

  p_compare_no_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!mulEn && opCode[3:2] == 2'b10) |-> !resultWe);
endmodule

// File: tb/flag_alu_test.sv
module flag_alu_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  opCode = '0;
  logic        mulEn = 1'b0, accEn = 1'b0, setFlags = 1'b0;
  logic [31:0] opA = '0, opB = '0, opC = '0;
  logic [1:0]  shType = '0;
  logic [4:0]  shImm = '0;
  logic        shFromReg = 1'b0;
  logic [7:0]  shReg = '0;
  logic [31:0] result;
  logic        resultWe;
  logic [3:0]  flags;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  flag_alu uut (
    .clk(clk), .rstN(rstN), .opCode(opCode), .mulEn(mulEn), .accEn(accEn),
    .setFlags(setFlags), .opA(opA), .opB(opB), .opC(opC), .shType(shType),
    .shImm(shImm), .shFromReg(shFromReg), .shReg(shReg),
    .result(result), .resultWe(resultWe), .flags(flags)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic shift(input logic [1:0] t, input logic [4:0] imm, input logic fromReg, input logic [7:0] r);
    shType = t; shImm = imm; shFromReg = fromReg; shReg = r;
  endtask

  task automatic doOp(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b, input logic s);
    @(negedge clk);
    opCode = o; opA = a; opB = b; setFlags = s; mulEn = 1'b0; accEn = 1'b0;
    #2;
  endtask

  task automatic doMul(input logic acc, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] c, input logic s);
    @(negedge clk);
    opCode = 4'd10; opA = a; opB = b; opC = c; setFlags = s; mulEn = 1'b1; accEn = acc;
    #2;
  endtask

  task automatic stepFlags(input string tag, input logic [3:0] exp);
    @(posedge clk); #1;
    chk(tag, {28'd0, flags}, {28'd0, exp});
  endtask

  task automatic t_reset;
    chk("R13 flags after reset", {28'd0, flags}, 32'd0);
  endtask

  task automatic t_arith;
    shift(2'd0, 5'd0, 1'b0, 8'd0);
    doOp(4'd4, 32'd5, 32'd7, 1'b1);          chk("R1 ADD", result, 32'd12);
    stepFlags("R7 ADD flags", 4'b0000);
    doOp(4'd4, 32'h7FFFFFFF, 32'd1, 1'b1);   chk("R1 ADD ovf", result, 32'h80000000);
    stepFlags("R7 ADD signed ovf", 4'b1001);
    doOp(4'd4, 32'hFFFFFFFF, 32'd1, 1'b1);   chk("R1 ADD wrap", result, 32'd0);
    stepFlags("R7 ADD carry", 4'b0110);
    doOp(4'd5, 32'd10, 32'd20, 1'b0);        chk("R1 ADC C=1", result, 32'd31);
    doOp(4'd6, 32'd10, 32'd3, 1'b0);         chk("R1 SBC C=1", result, 32'd7);
    doOp(4'd2, 32'd3, 32'd5, 1'b1);          chk("R1 SUB", result, 32'hFFFFFFFE);
    stepFlags("R7 SUB borrow", 4'b1000);
    doOp(4'd5, 32'd10, 32'd20, 1'b0);        chk("R1 ADC C=0", result, 32'd30);
    doOp(4'd6, 32'd10, 32'd3, 1'b0);         chk("R1 SBC C=0", result, 32'd6);
    doOp(4'd2, 32'd5, 32'd3, 1'b1);          chk("R1 SUB no borrow", result, 32'd2);
    stepFlags("R7 SUB no borrow", 4'b0010);
    doOp(4'd2, 32'h80000000, 32'd1, 1'b1);   chk("R1 SUB ovf", result, 32'h7FFFFFFF);
    stepFlags("R7 SUB signed ovf", 4'b0011);
  endtask

  task automatic t_reverse;
    doOp(4'd3, 32'd3, 32'd10, 1'b0);         chk("R2 RSB", result, 32'd7);
    doOp(4'd7, 32'd3, 32'd10, 1'b0);         chk("R2 RSC C=1", result, 32'd7);
    doOp(4'd3, 32'd10, 32'd3, 1'b1);         chk("R2 RSB neg", result, 32'hFFFFFFF9);
    stepFlags("R7 RSB borrow", 4'b1000);
    doOp(4'd7, 32'd3, 32'd10, 1'b0);         chk("R2 RSC C=0", result, 32'd6);
    doOp(4'd3, 32'd1, 32'h80000000, 1'b1);   chk("R2 RSB ovf", result, 32'h7FFFFFFF);
    stepFlags("R7 RSB order ovf", 4'b0011);
  endtask

  task automatic t_logic;
    doOp(4'd0, 32'h55, 32'h41, 1'b0);        chk("R3 AND", result, 32'h41);
    chk("R4 AND writes", {31'd0, resultWe}, 32'd1);
    doOp(4'd14, 32'h7A, 32'hA9, 1'b0);       chk("R3 BIC", result, 32'h52);
    doOp(4'd1, 32'hF0F0, 32'h0FF0, 1'b0);    chk("R3 EOR", result, 32'hFF00);
    doOp(4'd12, 32'hF000, 32'h000F, 1'b0);   chk("R3 ORR", result, 32'hF00F);
    doOp(4'd13, 32'hDEAD, 32'h1234, 1'b0);   chk("R3 MOV", result, 32'h1234);
    doOp(4'd15, 32'hDEAD, 32'h0, 1'b0);      chk("R3 MVN", result, 32'hFFFFFFFF);
    chk("R4 MVN writes", {31'd0, resultWe}, 32'd1);
    chk("R5 flags held by logic", {28'd0, flags}, 32'h3);
  endtask

  task automatic t_compare;
    doOp(4'd11, 32'h7FFFFFFF, 32'd1, 1'b1);  chk("R4 CMN no write", {31'd0, resultWe}, 32'd0);
    stepFlags("R6 CMN flags", 4'b1001);
    doOp(4'd8, 32'hF0, 32'h0F, 1'b1);        chk("R4 TST no write", {31'd0, resultWe}, 32'd0);
    stepFlags("R6 TST zero, R8 C V kept", 4'b0101);
    doOp(4'd9, 32'h80000000, 32'd0, 1'b1);   chk("R4 TEQ no write", {31'd0, resultWe}, 32'd0);
    stepFlags("R6 TEQ negative", 4'b1001);
    doOp(4'd10, 32'd5, 32'd5, 1'b1);         chk("R4 CMP no write", {31'd0, resultWe}, 32'd0);
    stepFlags("R6 CMP equal", 4'b0110);
  endtask

  task automatic t_hold;
    doOp(4'd4, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0);
    stepFlags("R5 hold on ADD", 4'b0110);
    doOp(4'd2, 32'd0, 32'd1, 1'b0);
    stepFlags("R5 hold on SUB", 4'b0110);
    doMul(1'b0, 32'd0, 32'd9, 32'd0, 1'b0);
    stepFlags("R5 hold on MUL", 4'b0110);
  endtask

  task automatic t_shift;
    shift(2'd0, 5'd4, 1'b0, 8'd0);
    doOp(4'd13, 32'd0, 32'hF1, 1'b0);        chk("R9 LSL imm", result, 32'hF10);
    shift(2'd1, 5'd4, 1'b0, 8'd0);
    doOp(4'd13, 32'd0, 32'h80000010, 1'b0);  chk("R9 ASR imm", result, 32'hF8000001);
    shift(2'd2, 5'd8, 1'b0, 8'd0);
    doOp(4'd13, 32'd0, 32'h12345678, 1'b0);  chk("R9 ROR imm", result, 32'h78123456);
    shift(2'd2, 5'd0, 1'b1, 8'd36);
    doOp(4'd13, 32'd0, 32'h12345678, 1'b0);  chk("R10 ROR reg mod", result, 32'h81234567);
    shift(2'd3, 5'd2, 1'b0, 8'd0);
    doOp(4'd13, 32'd0, 32'd3, 1'b0);         chk("R9 type 3 as LSL", result, 32'hC);
    shift(2'd0, 5'd9, 1'b1, 8'd3);
    doOp(4'd13, 32'd0, 32'd1, 1'b0);         chk("R9 LSL reg", result, 32'd8);
    shift(2'd0, 5'd2, 1'b0, 8'd0);
    doOp(4'd4, 32'd1, 32'd5, 1'b0);          chk("R9 ADD shifted", result, 32'd21);
    shift(2'd0, 5'd3, 1'b0, 8'd0);
    doOp(4'd3, 32'd6, 32'd6, 1'b0);          chk("R2 R9 RSB shifted", result, 32'd42);
  endtask

  task automatic t_shift_big;
    shift(2'd0, 5'd0, 1'b1, 8'd33);
    doOp(4'd13, 32'd0, 32'hFFFFFFFF, 1'b1);  chk("R10 LSL 33", result, 32'd0);
    stepFlags("R10 LSL 33 carry", 4'b0100);
    shift(2'd0, 5'd0, 1'b1, 8'd32);
    doOp(4'd13, 32'd0, 32'd1, 1'b1);         chk("R10 LSL 32", result, 32'd0);
    stepFlags("R10 LSL 32 carry", 4'b0110);
    shift(2'd1, 5'd0, 1'b1, 8'd40);
    doOp(4'd13, 32'd0, 32'h80000000, 1'b1);  chk("R10 ASR 40", result, 32'hFFFFFFFF);
    stepFlags("R10 ASR 40 carry", 4'b1010);
    shift(2'd2, 5'd0, 1'b1, 8'd32);
    doOp(4'd13, 32'd0, 32'd1, 1'b1);         chk("R10 ROR 32", result, 32'd1);
    stepFlags("R10 ROR 32 carry", 4'b0000);
  endtask

  task automatic t_logic_carry;
    shift(2'd0, 5'd0, 1'b0, 8'd0);
    doOp(4'd4, 32'h7FFFFFFF, 32'd1, 1'b1);
    stepFlags("R7 set V", 4'b1001);
    shift(2'd0, 5'd1, 1'b0, 8'd0);
    doOp(4'd13, 32'd0, 32'h80000000, 1'b1);  chk("R8 MOV LSL1", result, 32'd0);
    stepFlags("R8 carry out, V kept", 4'b0111);
    shift(2'd0, 5'd0, 1'b0, 8'd0);
    doOp(4'd13, 32'd0, 32'd2, 1'b1);
    stepFlags("R8 zero amount keeps C", 4'b0011);
    shift(2'd1, 5'd1, 1'b0, 8'd0);
    doOp(4'd13, 32'd0, 32'd2, 1'b1);         chk("R8 MOV ASR1", result, 32'd1);
    stepFlags("R8 carry out 0", 4'b0001);
    shift(2'd1, 5'd2, 1'b0, 8'd0);
    doOp(4'd0, 32'hFF, 32'd3, 1'b1);         chk("R8 AND ASR2", result, 32'd0);
    stepFlags("R8 AND carry", 4'b0111);
  endtask

  task automatic t_mul;
    shift(2'd0, 5'd0, 1'b0, 8'd0);
    doOp(4'd2, 32'h80000000, 32'd1, 1'b1);
    stepFlags("R7 preset C V", 4'b0011);
    shift(2'd0, 5'd4, 1'b0, 8'd0);
    doMul(1'b0, 32'h10000, 32'h10000, 32'd0, 1'b1);
    chk("R11 MUL low word", result, 32'd0);
    chk("R11 R4 MUL writes", {31'd0, resultWe}, 32'd1);
    stepFlags("R12 MUL zero, C V kept", 4'b0111);
    doMul(1'b1, 32'hFFFFFFFF, 32'd1, 32'd0, 1'b1);
    chk("R11 MLA", result, 32'hFFFFFFFF);
    stepFlags("R12 MLA negative", 4'b1011);
    doMul(1'b0, 32'd7, 32'd6, 32'd100, 1'b1);
    chk("R11 MUL", result, 32'd42);
    stepFlags("R12 MUL positive", 4'b0011);
    doMul(1'b1, 32'd7, 32'd6, 32'd100, 1'b0);
    chk("R11 MLA acc", result, 32'd142);
    doMul(1'b0, 32'hFFFFFFFF, 32'd2, 32'd0, 1'b0);
    chk("R11 MUL truncate", result, 32'hFFFFFFFE);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_arith();
    t_reverse();
    t_logic();
    t_compare();
    t_hold();
    t_shift();
    t_shift_big();
    t_logic_carry();
    t_mul();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule